// File: doc/BRIEF.md
# Bit-Clock and Frame-Sync Generator

This block is the clock master of a serial audio port. It divides a reference clock down to a bit clock and counts bit clocks to mark out frames. A frame-sync pulse starts at the first bit of every frame, and both its period and its active width are set in bit clocks. The same counter serves the two usual framings. A width of half the frame gives a 50% duty sync, as used by I2S and left-justified links. A width field of zero gives a single-bit pulse, as used by DSP-style links.

Every numeric field is written as its value minus one. A divider field of 0 divides by one, a period field of P gives P+1 bit clocks per frame, and a width field of W keeps the sync active for W+1 bit clocks. The block also checks the programmed frame against the payload it must carry, which is the word length times the channel count. A frame that is too short is refused: the block raises an error flag and holds both clocks idle. Each output has its own polarity select. New settings wait for the end of the current frame, so a frame is never cut short.

Top module: `frame_clock_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `bclk_out`, `fsync_out` and `bw_err` are all 0 after that edge, whatever the other inputs are.
- R2: While running, `bclk_out` stays at each level for exactly `div_field`+1 reference cycles. The active level is 1 when `bclk_invert`=0.
- R3: Successive active-going edges of `fsync_out` are exactly 2*(`div_field`+1)*(`period_field`+1) reference cycles apart.
- R4: `fsync_out` stays active for (`width_field`+1) bit clocks, which is 2*(`div_field`+1)*(`width_field`+1) reference cycles, when `width_field` < `period_field`. A width field of 0 gives a one-bit pulse. A width field of (P+1)/2-1 gives a 50% duty.
- R5: Every active-going edge of `fsync_out` falls on the same reference cycle as an active-going edge of `bclk_out`. That is the start of bit 0 of the frame.
- R6: `fs_invert`=1 makes the active level of `fsync_out` 0, and `bclk_invert`=1 does the same for `bclk_out`. When idle, each output sits at its inactive level, which equals its invert input.
- R7: A configuration is accepted only when `period_field`+1 >= `word_len`*`chan_cnt`. Otherwise `bw_err` goes to 1 and both outputs stay at their inactive levels.
- R8: Any change of the configuration inputs made while running takes effect at the next frame boundary. The frame in progress finishes with its old settings.
- R9: If the configuration sampled at a frame boundary is refused, the current frame completes. `bw_err` then rises on the cycle at which the next frame sync would have become active, and the outputs stay idle from that point.
- R10: With `enable` low, both outputs reach their inactive levels and `bw_err` is 0 within two reference cycles. The configuration then follows the inputs.
- R11: When `enable` rises with an accepted configuration, `fsync_out` and `bclk_out` turn active two reference edges after the edge that samples `enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator when high |
| div_field | input | DIV_W (8) | Bit-clock half-period in reference cycles, minus one |
| period_field | input | PER_W (12) | Frame length in bit clocks, minus one |
| width_field | input | WID_W (8) | Frame-sync active width in bit clocks, minus one |
| word_len | input | WL_W (6) | Bits per word, used in the fit check |
| chan_cnt | input | CH_W (5) | Words per frame, used in the fit check |
| fs_invert | input | 1 | Inverts the frame-sync output |
| bclk_invert | input | 1 | Inverts the bit-clock output |
| bclk_out | output | 1 | Bit clock |
| fsync_out | output | 1 | Frame sync |
| bw_err | output | 1 | The configuration was refused because its frame is too short |

## Verification
The bench builds the block with its default widths: an 8-bit divider, a 12-bit period, an 8-bit width, a 6-bit word length and a 5-bit channel count. These widths let the table drive the divider to its top value of 255 and use multi-channel frames of several dozen bits. They also allow period values placed exactly at, and one below, the word-times-channel limit, so both sides of the fit comparison are reached. The directed tests change the settings in the middle of a frame, to a good configuration and to a refused one, and drop `enable` while the sync is active.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int unsigned DIV_W_DEF = 8;
  localparam int unsigned PER_W_DEF = 12;
  localparam int unsigned WID_W_DEF = 8;
  localparam int unsigned WL_W_DEF  = 6;
  localparam int unsigned CH_W_DEF  = 5;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fcg_ctrl.sv
// Run control and shadow configuration. The settings are loaded while idle or at a frame wrap.
module fcg_ctrl #(
  parameter int unsigned DIV_W = fcg_pkg::DIV_W_DEF,
  parameter int unsigned PER_W = fcg_pkg::PER_W_DEF,
  parameter int unsigned WID_W = fcg_pkg::WID_W_DEF,
  parameter int unsigned WL_W  = fcg_pkg::WL_W_DEF,
  parameter int unsigned CH_W  = fcg_pkg::CH_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_in,
  input  logic [PER_W-1:0] per_in,
  input  logic [WID_W-1:0] wid_in,
  input  logic [WL_W-1:0]  wl_in,
  input  logic [CH_W-1:0]  ch_in,
  input  logic             fs_inv_in,
  input  logic             bclk_inv_in,
  input  logic             frame_wrap,
  output logic             run,
  output logic             err,
  output logic [DIV_W-1:0] cfg_div,
  output logic [PER_W-1:0] cfg_per,
  output logic [WID_W-1:0] cfg_wid,
  output logic             cfg_fs_inv,
  output logic             cfg_bclk_inv
);
  localparam int unsigned CMP_W = fcg_pkg::max2(PER_W + 1, WL_W + CH_W);

  logic [CMP_W-1:0] frame_len;
  logic [CMP_W-1:0] need;
  logic             fits;
  logic             load;

  always_comb begin
    frame_len = CMP_W'(per_in) + CMP_W'(1);
    need      = CMP_W'(wl_in) * CMP_W'(ch_in);
    fits      = (frame_len >= need);
    load      = !run || frame_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run          <= 1'b0;
      err          <= 1'b0;
      cfg_div      <= '0;
      cfg_per      <= '0;
      cfg_wid      <= '0;
      cfg_fs_inv   <= 1'b0;
      cfg_bclk_inv <= 1'b0;
    end else begin
      if (load) begin
        cfg_div      <= div_in;
        cfg_per      <= per_in;
        cfg_wid      <= wid_in;
        cfg_fs_inv   <= fs_inv_in;
        cfg_bclk_inv <= bclk_inv_in;
        run          <= enable && fits;
        err          <= enable && !fits;
      end
      if (!enable) begin
        run <= 1'b0;
        err <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fcg_bitdiv.sv
// Half-period counter. The bit clock level toggles every div+1 reference cycles.
module fcg_bitdiv #(
  parameter int unsigned DIV_W = fcg_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             lvl,
  output logic             bit_end
);
  logic [DIV_W-1:0] half_cnt;
  logic             half_done;

  assign half_done = (half_cnt == div);
  assign bit_end   = run && half_done && !lvl;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      half_cnt <= '0;
      lvl      <= 1'b1;
    end else if (half_done) begin
      half_cnt <= '0;
      lvl      <= ~lvl;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fcg_framecnt.sv
// Bit counter within a frame and the frame-sync active window.
module fcg_framecnt #(
  parameter int unsigned PER_W = fcg_pkg::PER_W_DEF,
  parameter int unsigned WID_W = fcg_pkg::WID_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             bit_end,
  input  logic [PER_W-1:0] per,
  input  logic [WID_W-1:0] wid,
  output logic [PER_W-1:0] bit_cnt,
  output logic             frame_wrap,
  output logic             fs_lvl
);
  localparam int unsigned CW = fcg_pkg::max2(PER_W, WID_W);

  logic last;

  assign last       = (bit_cnt == per);
  assign frame_wrap = bit_end && last;
  assign fs_lvl     = run && (CW'(bit_cnt) <= CW'(wid));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      bit_cnt <= '0;
    end else if (bit_end) begin
      bit_cnt <= last ? '0 : bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/frame_clock_gen.sv
module frame_clock_gen #(
  parameter int unsigned DIV_W = fcg_pkg::DIV_W_DEF,
  parameter int unsigned PER_W = fcg_pkg::PER_W_DEF,
  parameter int unsigned WID_W = fcg_pkg::WID_W_DEF,
  parameter int unsigned WL_W  = fcg_pkg::WL_W_DEF,
  parameter int unsigned CH_W  = fcg_pkg::CH_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_field,
  input  logic [PER_W-1:0] period_field,
  input  logic [WID_W-1:0] width_field,
  input  logic [WL_W-1:0]  word_len,
  input  logic [CH_W-1:0]  chan_cnt,
  input  logic             fs_invert,
  input  logic             bclk_invert,
  output logic             bclk_out,
  output logic             fsync_out,
  output logic             bw_err
);
  logic             run;
  logic             err;
  logic [DIV_W-1:0] cfg_div;
  logic [PER_W-1:0] cfg_per;
  logic [WID_W-1:0] cfg_wid;
  logic             cfg_fs_inv;
  logic             cfg_bclk_inv;
  logic             lvl;
  logic             bit_end;
  logic             frame_wrap;
  logic             fsync_lvl;
  logic             bclk_vis;
  logic [PER_W-1:0] bit_cnt;

  fcg_ctrl #(
    .DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W), .WL_W(WL_W), .CH_W(CH_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable),
    .div_in(div_field), .per_in(period_field), .wid_in(width_field),
    .wl_in(word_len), .ch_in(chan_cnt),
    .fs_inv_in(fs_invert), .bclk_inv_in(bclk_invert),
    .frame_wrap(frame_wrap), .run(run), .err(err),
    .cfg_div(cfg_div), .cfg_per(cfg_per), .cfg_wid(cfg_wid),
    .cfg_fs_inv(cfg_fs_inv), .cfg_bclk_inv(cfg_bclk_inv)
  );

  fcg_bitdiv #(.DIV_W(DIV_W)) u_bitdiv (
    .clk(clk), .rst(rst), .run(run), .div(cfg_div),
    .lvl(lvl), .bit_end(bit_end)
  );

  fcg_framecnt #(.PER_W(PER_W), .WID_W(WID_W)) u_framecnt (
    .clk(clk), .rst(rst), .run(run), .bit_end(bit_end),
    .per(cfg_per), .wid(cfg_wid), .bit_cnt(bit_cnt),
    .frame_wrap(frame_wrap), .fs_lvl(fsync_lvl)
  );

  assign bclk_vis = run && lvl;

  // Output stage: all three outputs see the same single register of latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_out  <= 1'b0;
      fsync_out <= 1'b0;
      bw_err    <= 1'b0;
    end else begin
      bclk_out  <= bclk_vis ^ cfg_bclk_inv;
      fsync_out <= fsync_lvl ^ cfg_fs_inv;
      bw_err    <= err;
    end
  end
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker #(
  parameter int unsigned PER_W = fcg_pkg::PER_W_DEF
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             fs_inv,
  input logic             bclk_inv,
  input logic             bclk_out,
  input logic             fsync_out,
  input logic             bw_err,
  input logic             run,
  input logic             bclk_vis,
  input logic             fsync_lvl,
  input logic [PER_W-1:0] bit_cnt,
  input logic [PER_W-1:0] cfg_per
);
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && !$past(enable, 2) && !$past(enable, 3))
      |-> (bclk_out == $past(bclk_inv, 2) && fsync_out == $past(fs_inv, 2) && !bw_err)); // R10

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    bw_err |-> (bclk_out == $past(bclk_inv, 2) && fsync_out == $past(fs_inv, 2))); // R7

  AST_FS_ON_BIT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_lvl) |-> bclk_vis); // R5

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (run && !$stable(cfg_per)) |-> (bit_cnt == '0)); // R8

  AST_COUNT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    run |-> (bit_cnt <= cfg_per)); // R3
endmodule

bind frame_clock_gen fcg_checker #(.PER_W(PER_W)) u_fcg_checker (
  .clk(clk), .rst(rst), .enable(enable), .fs_inv(fs_invert), .bclk_inv(bclk_invert),
  .bclk_out(bclk_out), .fsync_out(fsync_out), .bw_err(bw_err), .run(run),
  .bclk_vis(bclk_vis), .fsync_lvl(fsync_lvl), .bit_cnt(bit_cnt), .cfg_per(cfg_per)
);

// File: tb/frame_clock_gen_bench.sv
`timescale 1ns/1ps
module frame_clock_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [7:0]  div_field = '0;
  logic [11:0] period_field = '0;
  logic [7:0]  width_field = '0;
  logic [5:0]  word_len = '0;
  logic [4:0]  chan_cnt = '0;
  logic        fs_invert = 1'b0;
  logic        bclk_invert = 1'b0;
  logic        bclk_out, fsync_out, bw_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frame_clock_gen u_frame_clock_gen (
    .clk(clk), .rst(rst), .enable(enable), .div_field(div_field),
    .period_field(period_field), .width_field(width_field), .word_len(word_len),
    .chan_cnt(chan_cnt), .fs_invert(fs_invert), .bclk_invert(bclk_invert),
    .bclk_out(bclk_out), .fsync_out(fsync_out), .bw_err(bw_err)
  );

  // div, period, width, word_len, chan_cnt, fs_invert, bclk_invert, refused
  localparam int VEC [0:7][0:7] = '{
    '{0,   31, 15, 16, 2, 0, 0, 0},
    '{1,   63, 31, 16, 2, 1, 0, 0},
    '{2,   15,  0,  8, 2, 0, 1, 0},
    '{0,   47,  0, 16, 3, 1, 1, 0},
    '{0,   30, 15, 16, 2, 0, 0, 1},
    '{3,    9,  4,  5, 2, 1, 0, 0},
    '{0,    7,  3,  4, 3, 0, 1, 1},
    '{255,  1,  0,  1, 2, 0, 0, 0}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic bit fs_act();
    return fsync_out ^ fs_invert;
  endfunction

  function automatic bit bc_act();
    return bclk_out ^ bclk_invert;
  endfunction

  // Steps until fsync turns active; returns the steps taken, or -1 on timeout.
  task automatic wait_fs_edge(output int t, output bit bc_aligned);
    bit prev_fs, prev_bc;
    t = -1;
    bc_aligned = 1'b0;
    for (int i = 1; i <= 6000; i++) begin
      prev_fs = fs_act();
      prev_bc = bc_act();
      step();
      if (fs_act() && !prev_fs) begin
        t = i;
        bc_aligned = bc_act() && !prev_bc;
        break;
      end
    end
  endtask

  task automatic set_cfg(input int d, input int p, input int w, input int wl,
                         input int ch, input int fi, input int bi);
    div_field    = 8'(d);
    period_field = 12'(p);
    width_field  = 8'(w);
    word_len     = 6'(wl);
    chan_cnt     = 5'(ch);
    fs_invert    = fi[0];
    bclk_invert  = bi[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int t, bh, fa, fp;
    bit al;

    // R1: reset wins over a valid running configuration and set inverts
    set_cfg(0, 15, 7, 8, 2, 1, 1);
    enable = 1'b1;
    repeat (4) step();
    check(bclk_out == 0 && fsync_out == 0 && bw_err == 0, "R1 reset idle",
          {bclk_out, fsync_out, bw_err}, 0);
    enable = 1'b0;
    step();
    rst = 1'b0;
    step();

    for (int v = 0; v < 8; v++) begin
      enable = 1'b0;
      set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
      repeat (3) step();
      // R6: idle levels follow the invert inputs
      check(bclk_out == bclk_invert && fsync_out == fs_invert, "R6 idle polarity",
            {bclk_out, fsync_out}, {bclk_invert, fs_invert});
      enable = 1'b1;
      if (VEC[v][7] != 0) begin
        repeat (4) step();
        check(bw_err == 1'b1, "R7 refused flag", bw_err, 1);
        al = 1'b1;
        for (int i = 0; i < 20; i++) begin
          step();
          if (bclk_out != bclk_invert || fsync_out != fs_invert) al = 1'b0;
        end
        check(al, "R7 outputs idle while refused", al, 1);
      end else begin
        wait_fs_edge(t, al);
        check(t > 0, "R11 frame sync appears", t, 2);
        check(al, "R5 sync on bit clock edge", al, 1);
        bh = -1; fa = -1; fp = -1;
        for (int i = 1; i <= 6000; i++) begin
          step();
          if (bh < 0 && !bc_act()) bh = i;
          if (fa < 0 && !fs_act()) fa = i;
          if (fa > 0 && fs_act()) begin
            fp = i;
            break;
          end
        end
        check(bh == VEC[v][0] + 1, "R2 bit clock half period", bh, VEC[v][0] + 1);
        check(fa == (VEC[v][2] + 1) * 2 * (VEC[v][0] + 1), "R4 sync width", fa,
              (VEC[v][2] + 1) * 2 * (VEC[v][0] + 1));
        check(fp == (VEC[v][1] + 1) * 2 * (VEC[v][0] + 1), "R3 frame period", fp,
              (VEC[v][1] + 1) * 2 * (VEC[v][0] + 1));
        check(bw_err == 1'b0, "R7 accepted no flag", bw_err, 0);
      end
    end

    // R11: start latency of two edges
    enable = 1'b0;
    set_cfg(0, 15, 7, 8, 2, 0, 0);
    repeat (3) step();
    enable = 1'b1;
    step();
    check(fsync_out == 0 && bclk_out == 0, "R11 not yet active", {fsync_out, bclk_out}, 0);
    step();
    check(fsync_out == 1 && bclk_out == 1, "R11 active after two edges",
          {fsync_out, bclk_out}, 3);

    // R8: a mid-frame change applies at the next boundary
    wait_fs_edge(t, al);
    set_cfg(0, 31, 15, 8, 2, 0, 0);
    wait_fs_edge(t, al);
    check(t == 32, "R8 old frame completes", t, 32);
    wait_fs_edge(t, al);
    check(t == 64, "R8 new frame length", t, 64);

    // R9: a refused change completes the frame, then stops with the flag
    set_cfg(0, 3, 1, 8, 2, 0, 0);
    t = -1;
    for (int i = 1; i <= 200; i++) begin
      step();
      if (bw_err) begin
        t = i;
        break;
      end
    end
    check(t == 64, "R9 flag at boundary", t, 64);
    repeat (2) step();
    check(fsync_out == 0 && bclk_out == 0, "R9 idle after refusal", {fsync_out, bclk_out}, 0);

    // R10: dropping enable mid-frame
    enable = 1'b0;
    set_cfg(1, 15, 7, 8, 2, 1, 0);
    repeat (3) step();
    enable = 1'b1;
    wait_fs_edge(t, al);
    repeat (3) step();
    enable = 1'b0;
    repeat (2) step();
    check(bclk_out == bclk_invert && fsync_out == fs_invert && !bw_err, "R10 disable idle",
          {bclk_out, fsync_out, bw_err}, {bclk_invert, fs_invert, 1'b0});

    finish_run();
  end
endmodule